// File: doc/BRIEF.md
# Chained Shift Register Output Driver

This block drives a daisy chain of serial-in, parallel-out shift registers that have a storage latch on their outputs. It uses three push-pull lines: serial data, shift clock and storage latch. A host asks for one of two operations through a small command port. The first operation clocks one byte into the chain, most significant bit first. The second issues a single latch pulse. Because the two operations are separate, the host can push several bytes down the chain and then update the outputs of every stage together with one latch.

For each bit, the driver first presents the bit on the data line and holds it for a configurable number of cycles. It then raises the shift clock for a configurable high width. After that it moves on to the next bit. The first byte shifted after a latch ends up in the stage farthest from the driver. Commands are accepted only while the block is idle. A busy flag covers the whole operation, and a one-cycle done pulse marks its end.

Top module: `sr_chain_drv`

## Requirements
- R1: While reset is asserted and after it is released, `ser_data`, `ser_clk`, `ser_latch`, `busy` and `done` are all low.
- R2: A command with `cmd_start`=1 and `cmd_latch`=0, sampled while idle, produces exactly 8 rising edges on `ser_clk`. At the k-th rising edge (k = 1..8), `ser_data` equals `cmd_byte[8-k]`, so bit 7 goes first.
- R3: Before each rising edge of `ser_clk`, `ser_data` holds its bit for at least SETUP_CYC system cycles. It does not change while `ser_clk` is high.
- R4: Every `ser_clk` pulse is high for exactly CLK_HIGH system cycles.
- R5: A shift command never raises `ser_latch`. The parallel outputs of the chain therefore keep their previous values until a latch command.
- R6: A command with `cmd_start`=1 and `cmd_latch`=1, sampled while idle, produces one `ser_latch` pulse exactly LAT_HIGH cycles wide. It produces no `ser_clk` pulse, and `cmd_byte` is ignored.
- R7: `busy` rises in the cycle after a command is accepted. It stays high for 8*(SETUP_CYC+CLK_HIGH) cycles for a shift and LAT_HIGH cycles for a latch. `done` is high for exactly one cycle, in the first cycle with `busy` low.
- R8: `cmd_start` while `busy` is high is ignored. The running operation's bits, pulse count and duration are unchanged, and no latch pulse is produced.
- R9: With two chained 8-bit stages, shifting byte A and then byte B and then latching shows A on the far stage and B on the near stage.
- R10: When idle, `ser_data`, `ser_clk` and `ser_latch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command request, sampled while idle |
| cmd_latch | input | 1 | 1 = latch pulse, 0 = shift one byte |
| cmd_byte | input | BYTE_W | Byte to shift (ignored for latch) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| ser_data | output | 1 | Serial data line to the chain |
| ser_clk | output | 1 | Shift clock line to the chain |
| ser_latch | output | 1 | Storage latch line to the chain |

## Verification
The hardest situation to reach from the ports is a fresh command arriving in the middle of a shift. That request carries the latch flag and a different byte, and it must neither alter the bit stream nor sneak in a latch pulse. The stimulus injects such a request at a chosen cycle inside a running shift. A bench-side model of two chained stages then confirms that the received bits, the pulse widths, the busy length and the latched outputs all match the original command. A second hard case is proving that a shift leaves the chain's outputs untouched. This is observed through the modelled parallel outputs, which are compared after every shift against the last latched value.

// File: rtl/sr_chain_pkg.sv
package sr_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLKHI = 2'd2,
    ST_LATHI = 2'd3
  } drv_state_e;

  // Largest of three phase lengths, used to size the shared phase counter.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles that busy stays high for one shifted byte.
  function automatic int unsigned shift_busy_cycles(input int unsigned bits,
                                                    input int unsigned setup,
                                                    input int unsigned hi);
    return bits * (setup + hi);
  endfunction

endpackage

// File: rtl/sr_phase_timer.sv
module sr_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sr_byte_shifter.sv
module sr_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              advance,
  output logic              next_msb,
  output logic              last_bit
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sh;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= load_byte;
      idx <= '0;
    end else if (advance) begin
      sh  <= {sh[BYTE_W-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  // Bit that becomes the data line value after the next advance.
  assign next_msb = sh[BYTE_W-2];
  assign last_bit = (idx == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/sr_chain_drv.sv
module sr_chain_drv
  import sr_chain_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int CLK_HIGH  = 2,
  parameter int LAT_HIGH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_latch,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_latch
);

  localparam int CNT_W = $clog2(max3(SETUP_CYC, CLK_HIGH, LAT_HIGH) + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] CLKHI_LD = CNT_W'(CLK_HIGH - 1);
  localparam logic [CNT_W-1:0] LATHI_LD = CNT_W'(LAT_HIGH - 1);

  drv_state_e state;
  logic busy_q, done_q, dat_q, clk_q, lat_q;

  logic             phase_end;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             next_msb, last_bit;

  // Named internal events, also observed by the bound checker.
  logic accept;      // command taken this cycle
  logic bit_strobe;  // shift clock falls this cycle
  logic in_shift;    // a byte is being clocked out
  logic in_latch;    // a latch pulse is in progress

  assign accept     = (state == ST_IDLE) && cmd_start;
  assign bit_strobe = (state == ST_CLKHI) && phase_end;
  assign in_shift   = (state == ST_SETUP) || (state == ST_CLKHI);
  assign in_latch   = (state == ST_LATHI);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = SETUP_LD;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = cmd_latch ? LATHI_LD : SETUP_LD;
    end else if ((state == ST_SETUP) && phase_end) begin
      tmr_load = 1'b1;
      tmr_val  = CLKHI_LD;
    end else if (bit_strobe && !last_bit) begin
      tmr_load = 1'b1;
      tmr_val  = SETUP_LD;
    end
  end

  sr_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_end)
  );

  sr_byte_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && !cmd_latch),
    .load_byte (cmd_byte),
    .advance   (bit_strobe && !last_bit),
    .next_msb  (next_msb),
    .last_bit  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dat_q  <= 1'b0;
      clk_q  <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            busy_q <= 1'b1;
            if (cmd_latch) begin
              state <= ST_LATHI;
              lat_q <= 1'b1;
            end else begin
              state <= ST_SETUP;
              dat_q <= cmd_byte[BYTE_W-1];
            end
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            state <= ST_CLKHI;
            clk_q <= 1'b1;
          end
        end
        ST_CLKHI: begin
          if (phase_end) begin
            clk_q <= 1'b0;
            if (last_bit) begin
              state  <= ST_IDLE;
              dat_q  <= 1'b0;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              state <= ST_SETUP;
              dat_q <= next_msb;
            end
          end
        end
        ST_LATHI: begin
          if (phase_end) begin
            state  <= ST_IDLE;
            lat_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign ser_data  = dat_q;
  assign ser_clk   = clk_q;
  assign ser_latch = lat_q;

endmodule

// File: rtl/sr_chain_drv_chk.sv
module sr_chain_drv_chk #(
  parameter int CLK_HIGH = 2,
  parameter int LAT_HIGH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_latch,
  input logic in_shift,
  input logic in_latch
);

  logic [15:0] clk_run, lat_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_run <= '0;
      lat_run <= '0;
    end else begin
      clk_run <= ser_clk   ? clk_run + 1'b1 : '0;
      lat_run <= ser_latch ? lat_run + 1'b1 : '0;
    end
  end

  assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_data && !ser_clk && !ser_latch));

  assert_setup_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  assert_hold_while_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_clk_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (clk_run == 16'(CLK_HIGH)));

  assert_no_latch_in_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |-> !ser_latch);

  assert_latch_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_latch) |-> (lat_run == 16'(LAT_HIGH)));

  assert_no_clk_in_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_latch |-> (!ser_clk && !ser_data));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_ignore_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start && in_shift) |=> !in_latch);

endmodule

bind sr_chain_drv sr_chain_drv_chk #(.CLK_HIGH(CLK_HIGH), .LAT_HIGH(LAT_HIGH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .busy      (busy),
  .done      (done),
  .ser_data  (ser_data),
  .ser_clk   (ser_clk),
  .ser_latch (ser_latch),
  .in_shift  (in_shift),
  .in_latch  (in_latch)
);

// File: tb/test_sr_chain_drv.sv
module test_sr_chain_drv;

  localparam int S  = 2;
  localparam int CH = 2;
  localparam int LH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic cmd_latch = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic busy, done, ser_data, ser_clk, ser_latch;

  always #10 clk = ~clk;

  sr_chain_drv #(.BYTE_W(8), .SETUP_CYC(S), .CLK_HIGH(CH), .LAT_HIGH(LH)) i_sr_chain_drv (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_latch(cmd_latch),
    .cmd_byte(cmd_byte), .busy(busy), .done(done), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_latch(ser_latch)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Scoreboard queues filled by the driver tasks.
  logic        exp_bits[$];
  logic [15:0] exp_par[$];

  // Bench model of two chained stages: near takes ser_data, far takes near's top bit.
  logic [7:0] m_near = 8'h00, m_far = 8'h00;
  logic [15:0] m_par = 16'h0000;
  logic [7:0] exp_near = 8'h00, exp_far = 8'h00;
  logic [15:0] exp_lat = 16'h0000;

  logic p_clk = 1'b0, p_lat = 1'b0, p_dat = 1'b0;
  int   dat_run = 0, clk_hi = 0, lat_hi = 0;

  // Monitor: samples on the falling edge.
  always @(negedge clk) begin
    logic b;
    logic [15:0] pv;
    if (rst_n) begin
      dat_run = (ser_data != p_dat) ? 1 : dat_run + 1;
      if (ser_clk && !p_clk) begin
        check(dat_run >= S + 1, "R3 setup", dat_run, S + 1);
        if (exp_bits.size() == 0) begin
          check(1'b0, "R2 unexpected clock", 1, 0);
        end else begin
          b = exp_bits.pop_front();
          check(ser_data == b, "R2 bit", ser_data, b);
        end
        m_far  = {m_far[6:0], m_near[7]};
        m_near = {m_near[6:0], ser_data};
      end
      if (ser_clk && p_clk) check(ser_data == p_dat, "R3 hold", ser_data, p_dat);
      clk_hi = ser_clk ? clk_hi + 1 : clk_hi;
      if (!ser_clk && p_clk) begin
        check(clk_hi == CH, "R4 clk width", clk_hi, CH);
        clk_hi = 0;
      end
      if (ser_latch && !p_lat) begin
        m_par = {m_far, m_near};
        if (exp_par.size() == 0) begin
          check(1'b0, "R5/R8 unexpected latch", 1, 0);
        end else begin
          pv = exp_par.pop_front();
          check(m_par == pv, "R6/R9 latched", m_par, pv);
        end
      end
      lat_hi = ser_latch ? lat_hi + 1 : lat_hi;
      if (!ser_latch && p_lat) begin
        check(lat_hi == LH, "R6 latch width", lat_hi, LH);
        lat_hi = 0;
      end
      if (!busy) check(!ser_data && !ser_clk && !ser_latch, "R10 idle lines",
                       {ser_data, ser_clk, ser_latch}, 0);
      p_clk = ser_clk; p_lat = ser_latch; p_dat = ser_data;
    end
  end

  // Driver: shift one byte; inj > 0 injects a latch request at that busy cycle.
  task automatic shift_cmd(input logic [7:0] bv, input int inj);
    int n;
    for (int i = 7; i >= 0; i--) exp_bits.push_back(bv[i]);
    exp_far  = exp_near;
    exp_near = bv;
    cmd_byte = bv; cmd_latch = 1'b0; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
      if (n == inj) begin
        cmd_start = 1'b1; cmd_latch = 1'b1; cmd_byte = ~bv;  // R8 stimulus
      end else begin
        cmd_start = 1'b0; cmd_latch = 1'b0;
      end
    end
    cmd_start = 1'b0; cmd_latch = 1'b0;
    check(n == 8 * (S + CH), "R7 shift busy", n, 8 * (S + CH));
    check(done == 1'b1, "R7 done", done, 1);
    check(m_par == exp_lat, "R5 outputs unchanged", m_par, exp_lat);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(exp_bits.size() == 0, "R2 bit count", exp_bits.size(), 0);
  endtask

  task automatic latch_cmd();
    int n;
    exp_lat = {exp_far, exp_near};
    exp_par.push_back(exp_lat);
    cmd_byte = 8'h5A; cmd_latch = 1'b1; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_latch = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == LH, "R7 latch busy", n, LH);
    check(done == 1'b1, "R7 done latch", done, 1);
    check(m_par == exp_lat, "R6 outputs updated", m_par, exp_lat);
    check(exp_par.size() == 0, "R6 single latch", exp_par.size(), 0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({ser_data, ser_clk, ser_latch, busy, done} == 5'b0, "R1 in reset",
          {ser_data, ser_clk, ser_latch, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({ser_data, ser_clk, ser_latch, busy, done} == 5'b0, "R1 after reset",
          {ser_data, ser_clk, ser_latch, busy, done}, 0);

    shift_cmd(8'hA5, 0);
    latch_cmd();
    // R9: first byte shifted lands in the far stage.
    shift_cmd(8'h11, 0);
    shift_cmd(8'h22, 0);
    latch_cmd();
    check(m_par == 16'h1122, "R9 chain order", m_par, 16'h1122);
    // Corner patterns.
    shift_cmd(8'h00, 0);
    shift_cmd(8'hFF, 0);
    latch_cmd();
    check(m_par == 16'h00FF, "R9 all-zero/all-one", m_par, 16'h00FF);
    latch_cmd();  // repeated latch, outputs unchanged
    // R8: injected requests during shifts.
    shift_cmd(8'h81, 3);
    shift_cmd(8'h7E, 8 * (S + CH) - 1);
    latch_cmd();
    check(m_par == 16'h817E, "R8 ignored requests", m_par, 16'h817E);
    shift_cmd(8'hC3, 0);
    check(m_par == 16'h817E, "R5 shift without latch", m_par, 16'h817E);
    latch_cmd();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

endmodule